// File: doc/BRIEF.md
# GPIO Pin Register Controller

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins (94 by default). Software reaches it through a plain 32-bit write/read port with byte addresses. The registers come in two kinds. Bitmapped words hold one bit per pin, with pin n at bit n%32 of word n/32. Each pin also has a pair of configuration words.

The bitmapped words cover four things: ownership, interrupt enable, interrupt status and one global control word. The configuration pair holds the output level, the sensed input level, the direction, the GPIO/native select, the trigger kind, the interrupt polarity, the input-sense disable and the weak-pull code.

The controller drives pad output and output-enable, and samples pad inputs through a two-flop synchroniser. It also hands the sensed level, the trigger kind, the polarity and the enable of each pin to a separate edge/level detector. Detection events come back from that detector into the sticky status bits. The combined interrupt line is high while any status bit is set whose enable bit is also set.

Top module: `gpio_regctl`

## Requirements
- R1: After reset, every first config word reads 0x00000004 (input direction) and every second config word reads 0x00000004 (sensing off). Enable and status bitmaps read 0, the ownership bitmap reads the OWN_INIT parameter, and `pad_oe`, `pad_out` and `irq_out` are 0.
- R2: Bitmapped words sit at a 4-byte stride with pin n in word n/32 at bit n%32. Ownership starts at byte 0x00, status at 0x80 and enable at 0x90, and the global control word at 0x7C reads back what was written and appears on `gctl_out`.
- R3: The first config word of pin n is at 0x100+8n. Its writable fields are bit 31 (output level), bit 4 (1 = level trigger), bit 3 (invert), bit 2 (1 = input) and bit 0 (1 = GPIO); every other bit is written as nothing and reads 0, except bit 30.
- R4: The second config word of pin n is at 0x104+8n, with bit 2 = input-sense disable and bits 1:0 = weak-pull code, which drives `pad_pull[2n+1:2n]`; other bits read 0.
- R5: `pad_oe[n]` is 1 only when pin n is in GPIO mode, is set to output direction, and has ownership bit 1. `pad_out[n]` is the output-level bit when driven and 0 otherwise.
- R6: `pad_in` passes through two flops, so a change is seen on `det_level` and in bit 30 after the second rising edge. While sensing is disabled both read 0.
- R7: A pulse on `det_event[n]` sets status bit n. Writing 1 to a status bit clears it and writing 0 leaves it alone. An event in the same cycle as a clear keeps the bit set.
- R8: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set.
- R9: Reads of unmapped, misaligned or beyond-last-pin addresses, and of bitmap bits above the last pin, return 0. Writes there change no register.
- R10: `det_trig_level`, `det_invert` and `det_enable` follow each pin's trigger bit, invert bit and enable bit.
- R11: Bit 30 of the first config word is read-only; writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPIN | Raw pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_pull | output | 2*NPIN | Weak-pull code per pin |
| det_level | output | NPIN | Synchronised, sense-gated input level to the detector |
| det_trig_level | output | NPIN | 1 = level trigger, 0 = edge trigger |
| det_invert | output | NPIN | Trigger polarity invert |
| det_enable | output | NPIN | Interrupt enable per pin |
| det_event | input | NPIN | Detection pulses from the detector |
| irq_out | output | 1 | Combined interrupt |
| gctl_out | output | 32 | Global control word |

## Verification
Accesses are aimed at pins in each of the three bitmap words: pin 5, pins 37/40 and pin 70. This shows up a word-index or bit-index slip in the decode. All-ones writes to config words separate the writable fields from the reserved ones and from the read-only input bit. Output enable is checked with each of its three conditions removed in turn, so a missing term shows. Status is driven with an event alone, with a zero write, with a one write, and with an event and a clear in the same cycle, which separates set priority from clear priority. Enabled and disabled pins are also mixed, so the interrupt combine is tested for its masking.

// File: rtl/gpio_regctl_pkg.sv
package gpio_regctl_pkg;

    localparam int DW = 32;

    // word indices (byte address / 4) of the bitmap regions
    localparam int OWN_W  = 0;
    localparam int GCTL_W = 31;
    localparam int STAT_W = 32;
    localparam int EN_W   = 36;
    // first 8-byte slot (byte address / 8) of the per-pin region
    localparam int CFG_SLOT0 = 32;

    // field positions
    localparam int C1_OUT  = 31;
    localparam int C1_IN   = 30;
    localparam int C1_TRIG = 4;
    localparam int C1_INV  = 3;
    localparam int C1_DIR  = 2;
    localparam int C1_USE  = 0;
    localparam int C2_NOSENSE = 2;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_lvl: 1'b0, inv: 1'b0,
                                       dir_in: 1'b1, use_gpio: 1'b0,
                                       sense_off: 1'b1, pull: 2'b00};

    function automatic logic [DW-1:0] pack_cfg1(pin_cfg_t c, logic in_lvl);
        logic [DW-1:0] w;
        w = '0;
        w[C1_OUT]  = c.out_lvl;
        w[C1_IN]   = in_lvl;
        w[C1_TRIG] = c.trig_lvl;
        w[C1_INV]  = c.inv;
        w[C1_DIR]  = c.dir_in;
        w[C1_USE]  = c.use_gpio;
        return w;
    endfunction

    function automatic logic [DW-1:0] pack_cfg2(pin_cfg_t c);
        logic [DW-1:0] w;
        w = '0;
        w[C2_NOSENSE] = c.sense_off;
        w[1:0]        = c.pull;
        return w;
    endfunction

    function automatic pin_cfg_t unpack_wdata(logic [DW-1:0] w);
        pin_cfg_t c;
        c.out_lvl   = w[C1_OUT];
        c.trig_lvl  = w[C1_TRIG];
        c.inv       = w[C1_INV];
        c.dir_in    = w[C1_DIR];
        c.use_gpio  = w[C1_USE];
        c.sense_off = w[C2_NOSENSE];
        c.pull      = w[1:0];
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_regctl_pkg::*;
#(
    parameter logic OWN_RST = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_own,
    input  logic           wr_en,
    input  logic           wr_stat,
    input  logic           wbit,
    input  logic           wr_c1,
    input  logic           wr_c2,
    input  pin_cfg_t       wcfg,
    input  logic           in_sync,
    input  logic           event_in,
    output logic           own,
    output logic           en,
    output logic           stat,
    output logic [DW-1:0]  cfg1_word,
    output logic [DW-1:0]  cfg2_word,
    output logic           pad_out,
    output logic           pad_oe,
    output logic [1:0]     pull,
    output logic           level,
    output logic           trig,
    output logic           inv
);
    pin_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= CFG_RESET;
            own  <= OWN_RST;
            en   <= 1'b0;
            stat <= 1'b0;
        end else begin
            if (wr_c1) begin
                cfg.out_lvl  <= wcfg.out_lvl;
                cfg.trig_lvl <= wcfg.trig_lvl;
                cfg.inv      <= wcfg.inv;
                cfg.dir_in   <= wcfg.dir_in;
                cfg.use_gpio <= wcfg.use_gpio;
            end
            if (wr_c2) begin
                cfg.sense_off <= wcfg.sense_off;
                cfg.pull      <= wcfg.pull;
            end
            if (wr_own) own <= wbit;
            if (wr_en)  en  <= wbit;
            // a new event wins over a write-one clear in the same cycle
            stat <= event_in | (stat & ~(wr_stat & wbit));
        end
    end

    always_comb begin
        level     = in_sync & ~cfg.sense_off;
        pad_oe    = cfg.use_gpio & ~cfg.dir_in & own;
        pad_out   = pad_oe & cfg.out_lvl;
        pull      = cfg.pull;
        trig      = cfg.trig_lvl;
        inv       = cfg.inv;
        cfg1_word = pack_cfg1(cfg, level);
        cfg2_word = pack_cfg2(cfg);
    end
endmodule

// File: rtl/gpio_regctl.sv
module gpio_regctl
    import gpio_regctl_pkg::*;
#(
    parameter int              NPIN     = 94,
    parameter int              AW       = 12,
    parameter logic [NPIN-1:0] OWN_INIT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [2*NPIN-1:0] pad_pull,
    output logic [NPIN-1:0]   det_level,
    output logic [NPIN-1:0]   det_trig_level,
    output logic [NPIN-1:0]   det_invert,
    output logic [NPIN-1:0]   det_enable,
    input  logic [NPIN-1:0]   det_event,
    output logic              irq_out,
    output logic [DW-1:0]     gctl_out
);
    localparam int NW = (NPIN + DW - 1) / DW;   // words per bitmap (max 4)
    localparam int WW = AW - 2;                 // word-index width
    localparam int PW = AW - 3;                 // slot-index width

    logic [WW-1:0] word;
    logic [PW-1:0] pin_sel;
    logic          aligned, cfg_hit;
    logic [NW-1:0] own_wsel, stat_wsel, en_wsel;
    pin_cfg_t      wcfg;
    logic [NPIN-1:0] in_sync, own_v, stat_v;
    logic [DW-1:0] cfg1_rd [NPIN];
    logic [DW-1:0] cfg2_rd [NPIN];
    logic [NW*DW-1:0] own_ext, stat_ext, en_ext;
    logic [DW-1:0] gctl_q;

    assign word    = bus_addr[AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign pin_sel = bus_addr[AW-1:3] - PW'(CFG_SLOT0);
    assign cfg_hit = aligned && (bus_addr[AW-1:3] >= PW'(CFG_SLOT0)) && (pin_sel < PW'(NPIN));
    assign wcfg    = unpack_wdata(bus_wdata);

    for (genvar w = 0; w < NW; w++) begin : g_wsel
        assign own_wsel[w]  = bus_we && aligned && (word == WW'(OWN_W + w));
        assign stat_wsel[w] = bus_we && aligned && (word == WW'(STAT_W + w));
        assign en_wsel[w]   = bus_we && aligned && (word == WW'(EN_W + w));
    end

    always_ff @(posedge clk) begin
        if (rst) gctl_q <= '0;
        else if (bus_we && aligned && word == WW'(GCTL_W)) gctl_q <= bus_wdata;
    end
    assign gctl_out = gctl_q;

    gpio_sync2 #(.W(NPIN)) i_sync (.clk(clk), .rst(rst), .d(pad_in), .q(in_sync));

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gpio_pin_slice #(.OWN_RST(OWN_INIT[p])) i_slice (
            .clk       (clk),
            .rst       (rst),
            .wr_own    (own_wsel[p / DW]),
            .wr_en     (en_wsel[p / DW]),
            .wr_stat   (stat_wsel[p / DW]),
            .wbit      (bus_wdata[p % DW]),
            .wr_c1     (bus_we && cfg_hit && pin_sel == PW'(p) && !bus_addr[2]),
            .wr_c2     (bus_we && cfg_hit && pin_sel == PW'(p) &&  bus_addr[2]),
            .wcfg      (wcfg),
            .in_sync   (in_sync[p]),
            .event_in  (det_event[p]),
            .own       (own_v[p]),
            .en        (det_enable[p]),
            .stat      (stat_v[p]),
            .cfg1_word (cfg1_rd[p]),
            .cfg2_word (cfg2_rd[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .pull      (pad_pull[2*p +: 2]),
            .level     (det_level[p]),
            .trig      (det_trig_level[p]),
            .inv       (det_invert[p])
        );
    end

    assign irq_out = |(stat_v & det_enable);

    always_comb begin
        own_ext  = '0;
        stat_ext = '0;
        en_ext   = '0;
        own_ext[NPIN-1:0]  = own_v;
        stat_ext[NPIN-1:0] = stat_v;
        en_ext[NPIN-1:0]   = det_enable;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int w = 0; w < NW; w++) begin
                if (word == WW'(OWN_W + w))  bus_rdata = own_ext[w*DW +: DW];
                if (word == WW'(STAT_W + w)) bus_rdata = stat_ext[w*DW +: DW];
                if (word == WW'(EN_W + w))   bus_rdata = en_ext[w*DW +: DW];
            end
            if (word == WW'(GCTL_W)) bus_rdata = gctl_q;
            for (int p = 0; p < NPIN; p++) begin
                if (cfg_hit && pin_sel == PW'(p))
                    bus_rdata = bus_addr[2] ? cfg2_rd[p] : cfg1_rd[p];
            end
        end
    end
endmodule

// File: rtl/gpio_regctl_chk.sv
module gpio_regctl_chk #(
    parameter int NPIN = 94,
    parameter int AW   = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [31:0]     bus_rdata,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] det_level,
    input logic [NPIN-1:0] det_enable,
    input logic [NPIN-1:0] det_event,
    input logic            irq_out
);
    localparam logic [AW:0] CFG_END = (AW+1)'(256 + 8 * NPIN);

    // R5: a pad is never driven high while its enable is off
    p_out_needs_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R6: a sensed high must have been on the pad two edges earlier
    p_sync_depth_r6: assert property (@(posedge clk) disable iff (rst)
        (det_level & ~$past(pad_in, 2)) == '0);

    // R7: interrupt only rises after an event or a register write
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> ($past(|det_event) || $past(bus_we)));

    // R8: interrupt implies at least one enabled pin
    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (det_enable != '0));

    // R9: addresses past the last pin slot read zero
    p_beyond_zero_r9: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, bus_addr} >= CFG_END) |-> (bus_rdata == 32'h0));
endmodule

bind gpio_regctl gpio_regctl_chk #(.NPIN(NPIN), .AW(AW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .det_level  (det_level),
    .det_enable (det_enable),
    .det_event  (det_event),
    .irq_out    (irq_out)
);

// File: tb/test_gpio_regctl.sv
`timescale 1ns/1ps
module test_gpio_regctl;
    localparam int NPIN = 94;
    localparam int AW   = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out, pad_oe;
    logic [2*NPIN-1:0] pad_pull;
    logic [NPIN-1:0]   det_level, det_trig_level, det_invert, det_enable;
    logic [NPIN-1:0]   det_event = '0;
    logic              irq_out;
    logic [31:0]       gctl_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_regctl #(.NPIN(NPIN), .AW(AW)) i_gpio_regctl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .det_level(det_level), .det_trig_level(det_trig_level),
        .det_invert(det_invert), .det_enable(det_enable),
        .det_event(det_event), .irq_out(irq_out), .gctl_out(gctl_out)
    );

    function automatic logic [AW-1:0] c1(int p); return AW'(256 + 8*p); endfunction
    function automatic logic [AW-1:0] c2(int p); return AW'(260 + 8*p); endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(logic [AW-1:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic t_reset();
        rd_check(c1(0), 32'h4, "R1 cfg1 pin0");
        rd_check(c2(0), 32'h4, "R1 cfg2 pin0");
        rd_check(c1(93), 32'h4, "R1 cfg1 pin93");
        rd_check(12'h000, 32'hFFFF_FFFF, "R1 own word0");
        rd_check(12'h008, 32'h3FFF_FFFF, "R1 own word2");
        rd_check(12'h090, 32'h0, "R1 enable word0");
        rd_check(12'h084, 32'h0, "R1 status word1");
        check(pad_oe === '0 && pad_out === '0, "R1 pads", {31'b0, |pad_oe}, 32'h0);
        check(irq_out === 1'b0, "R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_bitmap();
        wr(12'h094, 32'hA5A5_0001);
        rd_check(12'h094, 32'hA5A5_0001, "R2 enable word1");
        check(det_enable[32] === 1'b1 && det_enable[33] === 1'b0, "R10 enable export",
              {30'b0, det_enable[33:32]}, 32'h1);
        wr(12'h098, 32'hFFFF_FFFF);
        rd_check(12'h098, 32'h3FFF_FFFF, "R9 bits above last pin");
        wr(12'h07C, 32'hDEAD_BEEF);
        rd_check(12'h07C, 32'hDEAD_BEEF, "R2 global control");
        check(gctl_out === 32'hDEAD_BEEF, "R2 gctl_out", gctl_out, 32'hDEAD_BEEF);
        wr(12'h094, 32'h0);
        wr(12'h098, 32'h0);
    endtask

    task automatic t_cfg();
        wr(c1(37), 32'hFFFF_FFFF);
        rd_check(c1(37), 32'h8000_001D, "R3 cfg1 writable fields");
        check(det_trig_level[37] === 1'b1 && det_invert[37] === 1'b1, "R10 trig/inv export",
              {30'b0, det_trig_level[37], det_invert[37]}, 32'h3);
        wr(c2(37), 32'hFFFF_FFFF);
        rd_check(c2(37), 32'h7, "R4 cfg2 writable fields");
        check(pad_pull[75:74] === 2'b11, "R4 pull export", {30'b0, pad_pull[75:74]}, 32'h3);
        rd_check(c1(36), 32'h4, "R3 neighbour pin36 untouched");
        wr(c1(37), 32'h4);
        wr(c2(37), 32'h4);
    endtask

    task automatic t_drive();
        wr(c1(5), 32'h8000_0001);
        #1;
        check(pad_oe[5] === 1'b1 && pad_out[5] === 1'b1, "R5 driven high",
              {30'b0, pad_oe[5], pad_out[5]}, 32'h3);
        wr(12'h000, ~32'h20);
        #1;
        check(pad_oe[5] === 1'b0 && pad_out[5] === 1'b0, "R5 not owned",
              {30'b0, pad_oe[5], pad_out[5]}, 32'h0);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(c1(5), 32'h8000_0000);
        #1;
        check(pad_oe[5] === 1'b0, "R5 native mode", {31'b0, pad_oe[5]}, 32'h0);
        wr(c1(5), 32'h8000_0005);
        #1;
        check(pad_oe[5] === 1'b0, "R5 input direction", {31'b0, pad_oe[5]}, 32'h0);
        wr(c1(5), 32'h4);
    endtask

    task automatic t_sense();
        wr(c2(40), 32'h0);
        @(negedge clk);
        pad_in[40] = 1'b1;
        @(posedge clk); #1;
        check(det_level[40] === 1'b0, "R6 one edge not yet", {31'b0, det_level[40]}, 32'h0);
        @(posedge clk); #1;
        check(det_level[40] === 1'b1, "R6 two edges", {31'b0, det_level[40]}, 32'h1);
        rd_check(c1(40), 32'h4000_0004, "R6 input bit");
        wr(c1(40), 32'h0000_0004);
        rd_check(c1(40), 32'h4000_0004, "R11 input bit read-only");
        wr(c2(40), 32'h4);
        rd_check(c1(40), 32'h0000_0004, "R6 sensing off");
        check(det_level[40] === 1'b0, "R6 sensing off level", {31'b0, det_level[40]}, 32'h0);
        pad_in[40] = 1'b0;
    endtask

    task automatic t_irq();
        wr(12'h098, 32'h40);                 // enable pin 70
        @(negedge clk); det_event[70] = 1'b1;
        @(negedge clk); det_event[70] = 1'b0;
        rd_check(12'h088, 32'h40, "R7 event sets status");
        check(irq_out === 1'b1, "R8 irq on enabled", {31'b0, irq_out}, 32'h1);
        wr(12'h088, 32'h0);
        rd_check(12'h088, 32'h40, "R7 zero write keeps");
        wr(12'h088, 32'h40);
        rd_check(12'h088, 32'h0, "R7 one write clears");
        check(irq_out === 1'b0, "R8 irq after clear", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        det_event[70] = 1'b1; bus_we = 1'b1; bus_addr = 12'h088; bus_wdata = 32'h40;
        @(negedge clk);
        det_event[70] = 1'b0; bus_we = 1'b0;
        rd_check(12'h088, 32'h40, "R7 set wins over clear");
        wr(12'h088, 32'h40);
        @(negedge clk); det_event[71] = 1'b1;
        @(negedge clk); det_event[71] = 1'b0;
        rd_check(12'h088, 32'h80, "R7 status on disabled pin");
        check(irq_out === 1'b0, "R8 masked pin", {31'b0, irq_out}, 32'h0);
        wr(12'h088, 32'h80);
        wr(12'h098, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(12'h00C, 32'h0);
        wr(12'h08C, 32'hFFFF_FFFF);
        wr(c1(94), 32'hFFFF_FFFF);
        wr(12'h001, 32'h0);                  // misaligned own write
        rd_check(12'h00C, 32'h0, "R9 gap after own");
        rd_check(12'h08C, 32'h0, "R9 gap after status");
        rd_check(c1(94), 32'h0, "R9 pin94 cfg1");
        rd_check(c2(94), 32'h0, "R9 pin94 cfg2");
        rd_check(12'hFFC, 32'h0, "R9 top of space");
        rd_check(12'h101, 32'h0, "R9 misaligned read");
        rd_check(12'h000, 32'hFFFF_FFFF, "R9 own unchanged");
        rd_check(c1(93), 32'h4, "R9 pin93 unchanged");
        rd_check(12'h090, 32'h0, "R9 enable unchanged");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_bitmap();
        t_cfg();
        t_drive();
        t_sense();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule